// File: doc/BRIEF.md
# Audio Clock Regeneration Divider

This block derives an audio sample-rate strobe from a fixed 25.0 MHz TMDS character clock. It applies the relation 128·fs = fTMDS·N/CTS: on every character clock a fractional accumulator adds N. Whenever the running sum reaches CTS, the block removes CTS from the sum and issues one tick at 128·fs. The long-run tick rate is therefore exact and carries no rounding drift. A 7-bit divider turns the ticks into a one-cycle strobe at fs. A separate counter marks the end of each CTS-long period of character clocks. A link transmitter can use that marker to report a measured CTS value next to the N value that the block presents.

A 3-bit select input picks one of seven sample rates. The matching N and CTS pair is presented on the outputs so the transmitter can send both to the sink. When the select changes, the block restarts its arithmetic cleanly. The one unused code parks the block with every output at zero.

Top module: `audio_clk_regen`

## Requirements
- R1: The select code maps to the pair (N, CTS) as follows. Code 0 gives 32 kHz (4608, 28125). Code 1 gives 44.1 kHz (7056, 31250). Code 2 gives 48 kHz (6912, 28125). Code 3 gives 88.2 kHz (14112, 31250). Code 4 gives 96 kHz (13824, 28125). Code 5 gives 176.4 kHz (28224, 31250). Code 6 gives 192 kHz (27648, 28125). The pair appears on `n_value` and `cts_value` from the first clock edge that sees the code.
- R2: Code 7 is not a rate. While it is in force, `n_value` and `cts_value` read 0 and `tick_128fs`, `fs_strobe` and `cts_wrap` stay low.
- R3: Take K clock edges after a restart edge. After those K edges the number of cycles with `tick_128fs` high is exactly floor(K·N/CTS), and the internal remainder always stays below CTS.
- R4: `fs_strobe` is high for one cycle on every 128th tick counted from a restart, and only in a cycle where `tick_128fs` is also high. After K edges the count of strobes is floor(ticks/128).
- R5: `cts_wrap` pulses once in every CTS clock edges. The first pulse falls on the CTS-th edge after a restart, and that pulse coincides with a tick.
- R6: The block compares the select input with the code in force on each clock edge. If the two differ, that edge is a restart edge: the new code takes effect, the accumulator and both counters clear, and all three pulse outputs are low for that cycle.
- R7: While reset is active, every output is 0. The first edge after reset is released counts as a restart edge for whatever code is then on the select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TMDS character clock (25.0 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Sample-rate select code |
| n_value | output | 20 | N for the code in force, 0 when idle |
| cts_value | output | 20 | CTS for the code in force, 0 when idle |
| tick_128fs | output | 1 | One-cycle tick at 128·fs |
| fs_strobe | output | 1 | One-cycle strobe at fs |
| cts_wrap | output | 1 | One-cycle marker at the end of each CTS period |

## Verification
Every output is a register, or is decoded from the registered code, so all outputs change on the clock edge that samples an input. The bench therefore changes the select on a falling edge. It waits for the rising edge that restarts the block and reads results only on later falling edges. At the falling edge just after the restart edge, the bench checks the new N and CTS and confirms that the pulses are idle. It then counts ticks, strobes and wraps over the next K falling edges, one per rising edge, and compares the totals with floor(K·N/CTS) and the related expressions. For three rates the window is exactly CTS edges, so exactly N ticks and one wrap are due.

// File: rtl/audio_clk_regen.sv
module audio_clk_regen #(
  parameter int W    = 20,
  parameter int DIVW = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   rate_sel,
  output logic [W-1:0] n_value,
  output logic [W-1:0] cts_value,
  output logic         tick_128fs,
  output logic         fs_strobe,
  output logic         cts_wrap
);
  localparam logic [2:0] IDLE_CODE = 3'd7;

  logic [2:0]    sel_q;
  logic [W-1:0]  acc;
  logic [W-1:0]  period_cnt;
  logic [DIVW-1:0] div_cnt;
  logic [W:0]    sum;
  logic          hit, active, change;

  always_comb begin
    case (sel_q)
      3'd0: begin n_value = W'(4608);  cts_value = W'(28125); end
      3'd1: begin n_value = W'(7056);  cts_value = W'(31250); end
      3'd2: begin n_value = W'(6912);  cts_value = W'(28125); end
      3'd3: begin n_value = W'(14112); cts_value = W'(31250); end
      3'd4: begin n_value = W'(13824); cts_value = W'(28125); end
      3'd5: begin n_value = W'(28224); cts_value = W'(31250); end
      3'd6: begin n_value = W'(27648); cts_value = W'(28125); end
      default: begin n_value = '0; cts_value = '0; end
    endcase
  end

  assign active = (cts_value != '0);
  assign change = (rate_sel != sel_q);
  assign sum    = {1'b0, acc} + {1'b0, n_value};
  assign hit    = sum >= {1'b0, cts_value};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= IDLE_CODE;
      acc        <= '0;
      period_cnt <= '0;
      div_cnt    <= '0;
      tick_128fs <= 1'b0;
      fs_strobe  <= 1'b0;
      cts_wrap   <= 1'b0;
    end else if (change || !active) begin
      sel_q      <= rate_sel;
      acc        <= '0;
      period_cnt <= '0;
      div_cnt    <= '0;
      tick_128fs <= 1'b0;
      fs_strobe  <= 1'b0;
      cts_wrap   <= 1'b0;
    end else begin
      if (hit) begin
        acc     <= W'(sum - {1'b0, cts_value});
        div_cnt <= div_cnt + 1'b1;
      end else begin
        acc     <= sum[W-1:0];
      end
      tick_128fs <= hit;
      fs_strobe  <= hit && (div_cnt == '1);
      if (period_cnt == cts_value - 1'b1) begin
        period_cnt <= '0;
        cts_wrap   <= 1'b1;
      end else begin
        period_cnt <= period_cnt + 1'b1;
        cts_wrap   <= 1'b0;
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (n_value == '0) |-> (!tick_128fs && !fs_strobe && !cts_wrap));

  p_acc_below_cts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_value == '0) || (acc < cts_value));

  p_fs_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fs_strobe |-> tick_128fs);

  p_fs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fs_strobe |=> !fs_strobe);

  p_wrap_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cts_wrap |-> tick_128fs);

  p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> (!tick_128fs && !fs_strobe && !cts_wrap && acc == '0 && period_cnt == '0));
endmodule

// File: tb/audio_clk_regen_bench.sv
module audio_clk_regen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic [19:0] n_value, cts_value;
  logic        tick_128fs, fs_strobe, cts_wrap;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  audio_clk_regen u_audio_clk_regen (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .n_value(n_value), .cts_value(cts_value),
    .tick_128fs(tick_128fs), .fs_strobe(fs_strobe), .cts_wrap(cts_wrap)
  );

  localparam int NV  = 7;
  localparam int T_SEL[NV] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int T_N[NV]   = '{4608, 7056, 6912, 14112, 13824, 28224, 27648};
  localparam int T_CTS[NV] = '{28125, 31250, 28125, 31250, 28125, 31250, 28125};
  localparam int T_WIN[NV] = '{28125, 31250, 2000, 2000, 2000, 2000, 28125};

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic count_window(input int k, input int n, input int cts);
    int ticks = 0, fss = 0, wraps = 0, stray = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (tick_128fs) ticks++;
      if (fs_strobe) fss++;
      if (cts_wrap) wraps++;
      if (fs_strobe && !tick_128fs) stray++;
    end
    check("R3", "tick count", ticks, int'((longint'(k) * n) / cts));
    check("R4", "fs count", fss, int'(((longint'(k) * n) / cts) / 128));
    check("R4", "fs without tick", stray, 0);
    check("R5", "wrap count", wraps, k / cts);
  endtask

  task automatic restart_and_check(input int sel, input int n, input int cts);
    @(posedge clk);
    @(negedge clk);
    check("R1", $sformatf("N sel=%0d", sel), int'(n_value), n);
    check("R1", $sformatf("CTS sel=%0d", sel), int'(cts_value), cts);
    check("R6", "pulses idle on restart", int'({tick_128fs, fs_strobe, cts_wrap}), 0);
  endtask

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "N in reset", int'(n_value), 0);
    check("R7", "pulses in reset", int'({tick_128fs, fs_strobe, cts_wrap}), 0);
    rst_n = 1'b1;
    restart_and_check(0, 4608, 28125);
    count_window(100, 4608, 28125);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rate_sel = 3'(T_SEL[v] == 0 ? 7 : T_SEL[v]);
      if (T_SEL[v] == 0) begin
        repeat (2) @(negedge clk);
        rate_sel = 3'd0;
      end
      restart_and_check(T_SEL[v], T_N[v], T_CTS[v]);
      count_window(T_WIN[v], T_N[v], T_CTS[v]);
    end

    @(negedge clk);
    rate_sel = 3'd7;
    @(posedge clk);
    begin
      int act = 0;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (tick_128fs || fs_strobe || cts_wrap) act++;
      end
      check("R2", "pulses on idle code", act, 0);
      check("R2", "N on idle code", int'(n_value), 0);
      check("R2", "CTS on idle code", int'(cts_value), 0);
    end

    @(negedge clk);
    rate_sel = 3'd2;
    restart_and_check(2, 6912, 28125);
    repeat (1000) @(negedge clk);
    rate_sel = 3'd4;
    restart_and_check(4, 13824, 28125);
    count_window(2000, 13824, 28125);

    @(negedge clk);
    rst_n = 1'b0;
    rate_sel = 3'd3;
    @(negedge clk);
    @(negedge clk);
    check("R7", "CTS in mid-run reset", int'(cts_value), 0);
    check("R7", "pulses in mid-run reset", int'({tick_128fs, fs_strobe, cts_wrap}), 0);
    rst_n = 1'b1;
    restart_and_check(3, 14112, 31250);
    count_window(2000, 14112, 31250);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule